// File: doc/BRIEF.md
# Time-Shared RGB-to-Luma Engine

This block turns a frame of three-component pixels into 8-bit luma samples. Each pixel arrives as three bytes, one per handshake, in the fixed order first, second, third component. Luma is formed in fixed point as Y = (66·a + 129·b + 25·c + 16·256 + 128) >> 8, which approximates 0.257·a + 0.504·b + 0.098·c + 16 with rounding. The result is clamped to 0..255.

The arithmetic uses one multiplier, one adder and two working registers. A four-phase controller cycles through three working steps per pixel. Each step multiplies the byte that has just arrived by its weight. In the same step the adder finishes partial sums left over from earlier steps, so the final add of one pixel overlaps the first multiply of the next. After the last pixel, one extra flush step completes the last sum. A `start` pulse while idle begins a frame of `PIXELS` pixels (64 by default). When the last luma value has been produced, `done` rises and stays high until the next start.

Both data interfaces are valid/ready. An input byte transfers on a clock edge where `in_valid` and `in_ready` are both high. An output transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The engine then withholds `in_ready` at the step that would produce the next result. Upstream may insert bubbles at any time.

Top module: `luma_rgb_engine`

## Requirements
- R1: Every output equals min(255, (66·a + 129·b + 25·c + 4224) >> 8) for the pixel it belongs to, with a, b and c the unsigned bytes of that pixel.
- R2: Input bytes are taken only on an `in_valid`/`in_ready` handshake. Successive bytes of a frame are assigned to a, b, c, a, b, c, …. `in_ready` is low while idle.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change on the next cycle.
- R4: A frame delivers exactly `PIXELS` outputs, in pixel order. No output appears after the last one until the next frame is started.
- R5: With `in_valid` and `out_ready` held high, a pixel is accepted every 3 cycles. `done` is seen high 3·`PIXELS`+1 cycles after the edge that samples `start`.
- R6: `done` rises in the cycle that the last output is registered. It stays high while idle, with `in_ready` low. It clears on the edge that samples `start`. A `start` pulse while a frame is running has no effect on the frame.
- R7: After reset, `out_valid`, `done` and `in_ready` are low.
- R8: A pixel of three zero bytes gives 16. A pixel of three 255 bytes gives 235.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a frame when sampled high while idle |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Engine takes the input byte on this edge |
| in_data | input | 8 | Pixel component byte (a, b, c order) |
| out_valid | output | 1 | Luma value is present |
| out_ready | input | 1 | Downstream takes the luma value |
| out_data | output | 8 | Luma value |
| done | output | 1 | Frame complete, held until next start |

## Verification
Some properties are checked by assertions on every cycle:
- output holding under back-pressure;
- the step order of the controller;
- the pixel count staying in range;
- `in_ready` staying low once `done` is set;
- a running frame surviving a stray `start`;
- every produced sum containing the offset and rounding bias.

Only the bench scenarios can show the remaining properties:
- that each luma value matches the quantized formula for its own pixel, which depends on the byte order and on the overlap of one pixel's final add with the next pixel's first multiply;
- that exactly one frame's worth of results comes out;
- the throughput of three cycles per pixel;
- the extreme values at all-zero and all-255 pixels.

// File: rtl/luma_pkg.sv
package luma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_A     = 3'd1,
    ST_B     = 3'd2,
    ST_C     = 3'd3,
    ST_FLUSH = 3'd4
  } luma_state_e;

  // Operand select: bit 1 only in the third-component step, bit 0 only in
  // the second-component step; first step and flush use 2'b00.
  function automatic logic [1:0] step_select(luma_state_e s);
    return {(s == ST_C), (s == ST_B)};
  endfunction

endpackage

// File: rtl/luma_ctrl.sv
module luma_ctrl
  import luma_pkg::*;
#(
  parameter int PIXELS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic       out_free,
  output logic       in_ready,
  output logic       step_en,
  output logic [1:0] step_sel,
  output logic       emit,
  output logic       done
);

  localparam int CNT_W = $clog2(PIXELS + 1);

  luma_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic             last_pix;

  assign last_pix = (cnt == CNT_W'(PIXELS - 1));
  assign step_sel = step_select(st);

  always_comb begin
    case (st)
      ST_A:        in_ready = out_free;
      ST_B, ST_C:  in_ready = 1'b1;
      default:     in_ready = 1'b0;
    endcase
    if (st == ST_FLUSH) step_en = out_free;
    else                step_en = in_valid && in_ready;
    emit = step_en && (((st == ST_A) && (cnt != '0)) || (st == ST_FLUSH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_A;
          cnt  <= '0;
          done <= 1'b0;
        end
        ST_A: if (step_en) st <= ST_B;
        ST_B: if (step_en) st <= ST_C;
        ST_C: if (step_en) begin
          cnt <= cnt + 1'b1;
          st  <= last_pix ? ST_FLUSH : ST_A;
        end
        ST_FLUSH: if (step_en) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2 / R5: steps advance in fixed order
  a_r5_a_then_b: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_A && step_en) |=> (st == ST_B));
  a_r2_b_then_c: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_B && step_en) |=> (st == ST_C));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PIXELS));
  a_r6_done_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_A || st == ST_B || st == ST_C) && start) |=> (st != ST_IDLE));

endmodule

// File: rtl/luma_dp.sv
module luma_dp #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 8,
  parameter int COEF_A = 66,
  parameter int COEF_B = 129,
  parameter int COEF_C = 25,
  parameter int OFFSET = 16,
  localparam int ACC_W = DATA_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] comp,
  output logic [ACC_W-1:0]  sum
);

  localparam int PROD_W = DATA_W + FRAC_W;
  localparam int BIAS_I = (OFFSET << FRAC_W) + (1 << (FRAC_W - 1));
  localparam logic [ACC_W-1:0] BIAS = ACC_W'(BIAS_I);

  logic [FRAC_W-1:0] coef;
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  r1, r2, add_b;

  // Single multiplier with coefficient multiplexer
  always_comb begin
    case (sel)
      2'b01:   coef = FRAC_W'(COEF_B);
      2'b10:   coef = FRAC_W'(COEF_C);
      default: coef = FRAC_W'(COEF_A);
    endcase
    prod = PROD_W'(comp) * PROD_W'(coef);
  end

  // Single adder: r1 plus either the bias (second step) or r2
  assign add_b = (sel == 2'b01) ? BIAS : r2;
  assign sum   = r1 + add_b;

  // Value registers, written on every working step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= '0;
      r2 <= '0;
    end else if (en) begin
      if (sel == 2'b00) begin
        r1 <= ACC_W'(prod);
        r2 <= sum;
      end else begin
        r1 <= sum;
        r2 <= ACC_W'(prod);
      end
    end
  end

endmodule

// File: rtl/luma_out.sv
module luma_out #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ACC_W-1:0]  sum_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_free
);

  localparam logic [ACC_W-1:0] MAXV = ACC_W'((1 << DATA_W) - 1);

  logic [ACC_W-1:0]  shifted;
  logic [DATA_W-1:0] clamped;

  assign shifted  = sum_in >> FRAC_W;
  assign clamped  = (shifted > MAXV) ? '1 : shifted[DATA_W-1:0];
  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= clamped;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r3_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/luma_rgb_engine.sv
module luma_rgb_engine #(
  parameter int PIXELS = 64,
  parameter int DATA_W = 8,
  parameter int FRAC_W = 8,
  parameter int COEF_A = 66,
  parameter int COEF_B = 129,
  parameter int COEF_C = 25,
  parameter int OFFSET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);

  localparam int ACC_W  = DATA_W + FRAC_W + 2;
  localparam int BIAS_I = (OFFSET << FRAC_W) + (1 << (FRAC_W - 1));

  logic             step_en, emit, out_free;
  logic [1:0]       step_sel;
  logic [ACC_W-1:0] dp_sum;

  luma_ctrl #(.PIXELS(PIXELS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_free(out_free), .in_ready(in_ready), .step_en(step_en),
    .step_sel(step_sel), .emit(emit), .done(done)
  );

  luma_dp #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .COEF_A(COEF_A),
    .COEF_B(COEF_B), .COEF_C(COEF_C), .OFFSET(OFFSET)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .en(step_en), .sel(step_sel),
    .comp(in_data), .sum(dp_sum)
  );

  luma_out #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .sum_in(dp_sum),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_free(out_free)
  );

  // R1: every emitted sum carries offset and rounding bias
  a_r1_bias_present: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (dp_sum >= ACC_W'(BIAS_I)));

endmodule

// File: tb/luma_rgb_engine_bench.sv
module luma_rgb_engine_bench;

  localparam int PIX = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pa [PIX];
  logic [7:0] pb [PIX];
  logic [7:0] pc [PIX];
  int got [PIX];
  int done_at;
  int nout;

  always #2 clk = ~clk;

  luma_rgb_engine u_luma_rgb_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  function automatic int model(input int a, input int b, input int c);
    int v;
    v = (66 * a + 129 * b + 25 * c + 4224) >> 8;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Streams one frame; gap_mod/rdy_mod insert bubbles/stalls when non-zero.
  task automatic run_frame(input int gap_mod, input int rdy_mod, input bit poke);
    int idx;
    int cyc;
    bit held;
    int held_val;
    idx = 0; cyc = 0; nout = 0; done_at = -1; held = 0; held_val = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R6 done cleared by start", int'(done), 0);
    while (cyc < 5000) begin
      if (done && done_at < 0) done_at = cyc;
      if (done && nout == PIX) break;
      if (held) begin
        check(out_valid && out_data == held_val, "R3 held output", int'(out_data), held_val);
        held = 0;
      end
      out_ready = (rdy_mod == 0) || (cyc % rdy_mod != 0);
      in_valid  = (idx < 3 * PIX) && ((gap_mod == 0) || (cyc % gap_mod != 0));
      case (idx % 3)
        0: in_data = pa[(idx / 3) % PIX];
        1: in_data = pb[(idx / 3) % PIX];
        default: in_data = pc[(idx / 3) % PIX];
      endcase
      start = poke && (cyc == 50);
      #1;
      if (out_valid && out_ready) begin
        if (nout < PIX) begin
          got[nout] = int'(out_data);
          check(int'(out_data) == model(pa[nout], pb[nout], pc[nout]), "R1 luma value",
                int'(out_data), model(pa[nout], pb[nout], pc[nout]));
        end
        nout++;
      end else if (out_valid) begin
        held = 1; held_val = int'(out_data);
      end
      if (in_valid && in_ready) idx++;
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    check(cyc < 5000, "R4 frame completes", cyc, 0);
    check(nout == PIX, "R4 output count", nout, PIX);
    check(in_ready == 1'b0, "R6 no accept when done", int'(in_ready), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R4 no extra output", int'(out_valid), 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid at reset", int'(out_valid), 0);
    check(done == 1'b0, "R7 done at reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R2 idle not ready", int'(in_ready), 0);
    check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    in_valid = 1'b0;
  endtask

  task automatic t_ramp();
    for (int i = 0; i < PIX; i++) begin
      pa[i] = 8'(i * 4); pb[i] = 8'(255 - i * 3); pc[i] = 8'((i * i) % 256);
    end
    run_frame(0, 0, 0);
    check(done_at == 3 * PIX + 1, "R5 frame cycles", done_at, 3 * PIX + 1);
  endtask

  task automatic t_extremes();
    for (int i = 0; i < PIX; i++) begin
      case (i % 4)
        0: begin pa[i] = 8'd0;   pb[i] = 8'd0;   pc[i] = 8'd0;   end
        1: begin pa[i] = 8'd255; pb[i] = 8'd255; pc[i] = 8'd255; end
        2: begin pa[i] = 8'd255; pb[i] = 8'd0;   pc[i] = 8'(i);  end
        default: begin pa[i] = 8'(i); pb[i] = 8'd255; pc[i] = 8'd0; end
      endcase
    end
    run_frame(3, 4, 1);
    check(got[0] == 16, "R8 all-zero pixel", got[0], 16);
    check(got[1] == 235, "R8 all-255 pixel", got[1], 235);
  endtask

  task automatic t_idle_done();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      #1;
      check(done == 1'b1, "R6 done holds while idle", int'(done), 1);
      check(in_ready == 1'b0, "R2 no accept while idle", int'(in_ready), 0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp();
    t_idle_done();
    t_extremes();
    t_ramp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule